// File: doc/BRIEF.md
# Wake-Pin Interrupt Controller

This block collects interrupt and wake requests from a small set of external wake pins and from a few peripheral interrupt lines. Each wake pin passes through a two-flop synchroniser. A per-pin trigger mode then decides whether the pin's condition is met. The condition can be a level, a single edge, either edge, or nothing at all. When the condition is met, the pin's status bit is latched. The status bits are masked by an enable register, cleared by writing ones, and gated by a routing register before they are ORed into one shared pin interrupt output.

The same routing register passes each peripheral line to its own external output. It also holds one wake enable for every pin and every peripheral source. The wake request output is high while any source is active and wake-enabled. For a pin, "active" means its status bit is pending. Software reaches the registers through a plain 32-bit port. Writes are taken on the clock edge. Reads are combinational from the address.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset, status, enable and routing read as zero, every pin's mode field reads 4 (no trigger), so its configuration word reads 0x8 while the pin is low, and all outputs are low.
- R2: Register offsets are status 0x310, enable 0x314, clear 0x318 (reads zero), routing 0x31C, and pin n configuration 0x330+8n. A configuration word holds the synchronised pin value in bit 0, the mode in bits 3:1 and the pin hold control in bit 4. Bit 0 follows the pin two clock edges after it changes.
- R3: In mode 0 (level low) or 1 (level high), the status bit sets one edge after the synchronised level is active. If the level is still active after a clear, the bit sets again on the next edge.
- R4: Mode 3 (rising), mode 2 (falling) and mode 6 (either edge) set the status bit when the synchronised value differs from its value one cycle earlier in the selected direction.
- R5: Mode 4, and the unused codes 5 and 7, never set a status bit.
- R6: Writing 1 to bit n of the clear register clears status bit n. Writing 0 leaves it unchanged. A trigger and a clear of the same bit in one cycle leave the bit set.
- R7: pin_irq_o is high when, for some pin n, status[n], enable[n] and routing bit 8+n are all set.
- R8: periph_irq_o[k] equals periph_irq[k] AND routing bit k.
- R9: wake_o is high when some periph_irq[k] is high with routing bit 16+k set, or some status[n] is set with routing bit 24+n set.
- R10: While bit 4 of a pin's configuration word is set, that pin's status bit is held at zero and its trigger is ignored.
- R11: Bits for pins or peripheral lines that are not implemented read as zero and ignore writes. Configuration words of unimplemented pins and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| wake_pin | input | N_PINS | Asynchronous wake pin inputs |
| periph_irq | input | N_PERIPH | Peripheral interrupt lines |
| pin_irq_o | output | 1 | Shared interrupt for pending, enabled, routed pins |
| periph_irq_o | output | N_PERIPH | Routed peripheral interrupts |
| wake_o | output | 1 | Wake request |

## Verification
The hardest situations to reach from the ports are a clear write that lands on the same edge as a fresh trigger, and a level-mode pin whose level is still present when its status is cleared. Both depend on the three-edge synchroniser and detection latency. The directed part of the stimulus holds a level-mode pin active, issues clears at known offsets from the pin change, and reads status right after. A long random phase mixes pin toggles, mode changes, hold-bit writes and clears. In that phase, a cycle-level bench model predicts every read and every output.

// File: rtl/wic_pkg.sv
package wic_pkg;
    localparam int A_STATUS   = 32'h310;
    localparam int A_ENABLE   = 32'h314;
    localparam int A_CLEAR    = 32'h318;
    localparam int A_ROUTE    = 32'h31C;
    localparam int A_CFG0     = 32'h330;
    localparam int CFG_STRIDE = 8;

    localparam int RT_PER_EXT  = 0;
    localparam int RT_PIN_EXT  = 8;
    localparam int RT_PER_WAKE = 16;
    localparam int RT_PIN_WAKE = 24;
    localparam int MAX_SRC     = 8;

    localparam logic [2:0] TRIG_LOW  = 3'd0;
    localparam logic [2:0] TRIG_HIGH = 3'd1;
    localparam logic [2:0] TRIG_FALL = 3'd2;
    localparam logic [2:0] TRIG_RISE = 3'd3;
    localparam logic [2:0] TRIG_NONE = 3'd4;
    localparam logic [2:0] TRIG_ANY  = 3'd6;

    // Implemented bits of the routing register
    function automatic logic [31:0] route_mask(input int npin, input int nper);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < MAX_SRC; i++) begin
            if (i < nper) begin
                m[RT_PER_EXT + i]  = 1'b1;
                m[RT_PER_WAKE + i] = 1'b1;
            end
            if (i < npin) begin
                m[RT_PIN_EXT + i]  = 1'b1;
                m[RT_PIN_WAKE + i] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = async_in;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign cur  = sync_q.s2;
    assign prev = sync_q.prev;
endmodule

// File: rtl/wic_trig_detect.sv
module wic_trig_detect
    import wic_pkg::*;
(
    input  logic       cur,
    input  logic       prev,
    input  logic [2:0] mode,
    input  logic       hold,
    output logic       hit
);
    logic raw;

    always_comb begin
        unique case (mode)
            TRIG_LOW:  raw = !cur;
            TRIG_HIGH: raw = cur;
            TRIG_FALL: raw = prev && !cur;
            TRIG_RISE: raw = !prev && cur;
            TRIG_ANY:  raw = prev ^ cur;
            default:   raw = 1'b0;
        endcase
        hit = raw && !hold;
    end
endmodule

// File: rtl/wic_route.sv
module wic_route
    import wic_pkg::*;
#(
    parameter int N_PINS   = 4,
    parameter int N_PERIPH = 3
) (
    input  logic [N_PINS-1:0]   status,
    input  logic [N_PINS-1:0]   enable,
    input  logic [31:0]         route,
    input  logic [N_PERIPH-1:0] periph_irq,
    output logic                pin_irq_o,
    output logic [N_PERIPH-1:0] periph_irq_o,
    output logic                wake_o
);
    logic [N_PINS-1:0]   pin_ext_en, pin_wake_en;
    logic [N_PERIPH-1:0] per_ext_en, per_wake_en;

    always_comb begin
        pin_ext_en   = route[RT_PIN_EXT  +: N_PINS];
        pin_wake_en  = route[RT_PIN_WAKE +: N_PINS];
        per_ext_en   = route[RT_PER_EXT  +: N_PERIPH];
        per_wake_en  = route[RT_PER_WAKE +: N_PERIPH];
        pin_irq_o    = |(status & enable & pin_ext_en);
        periph_irq_o = periph_irq & per_ext_en;
        wake_o       = (|(periph_irq & per_wake_en)) | (|(status & pin_wake_en));
    end
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
    import wic_pkg::*;
#(
    parameter int N_PINS   = 4,
    parameter int N_PERIPH = 3,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [N_PINS-1:0]   wake_pin,
    input  logic [N_PERIPH-1:0] periph_irq,
    output logic                pin_irq_o,
    output logic [N_PERIPH-1:0] periph_irq_o,
    output logic                wake_o
);
    localparam logic [31:0] ROUTE_MASK = route_mask(N_PINS, N_PERIPH);
    localparam int          MODE_W     = 3 * N_PINS;

    typedef struct packed {
        logic [N_PINS-1:0] status;
        logic [N_PINS-1:0] enable;
        logic [N_PINS-1:0] prst;
        logic [MODE_W-1:0] mode;
        logic [31:0]       route;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [N_PINS-1:0] pin_cur, pin_prev, pin_hit;
    logic [N_PINS-1:0] status_vec, prst_vec;
    logic [MODE_W-1:0] mode_flat;
    logic              wr_enable, wr_clear, wr_route;
    logic [N_PINS-1:0] clr_mask;

    wic_sync #(.W(N_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_pin),
        .cur      (pin_cur),
        .prev     (pin_prev)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        wic_trig_detect u_det (
            .cur  (pin_cur[g]),
            .prev (pin_prev[g]),
            .mode (regs_q.mode[3*g +: 3]),
            .hold (regs_q.prst[g]),
            .hit  (pin_hit[g])
        );
    end

    assign status_vec = regs_q.status;
    assign prst_vec   = regs_q.prst;
    assign mode_flat  = regs_q.mode;

    always_comb begin
        wr_enable = reg_wr && (reg_addr == ADDR_W'(A_ENABLE));
        wr_clear  = reg_wr && (reg_addr == ADDR_W'(A_CLEAR));
        wr_route  = reg_wr && (reg_addr == ADDR_W'(A_ROUTE));
        clr_mask  = wr_clear ? reg_wdata[N_PINS-1:0] : '0;
    end

    // Next-state: a trigger in the same cycle as a clear wins
    always_comb begin
        regs_d        = regs_q;
        regs_d.status = ((regs_q.status & ~clr_mask) | pin_hit) & ~regs_q.prst;
        if (wr_enable) regs_d.enable = reg_wdata[N_PINS-1:0];
        if (wr_route)  regs_d.route  = reg_wdata & ROUTE_MASK;
        for (int i = 0; i < N_PINS; i++) begin
            if (reg_wr && (reg_addr == ADDR_W'(A_CFG0 + CFG_STRIDE * i))) begin
                regs_d.mode[3*i +: 3] = reg_wdata[3:1];
                regs_d.prst[i]        = reg_wdata[4];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.mode <= {N_PINS{TRIG_NONE}};
        end else begin
            regs_q      <= regs_d;
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_STATUS)) reg_rdata[N_PINS-1:0] = regs_q.status;
        if (reg_addr == ADDR_W'(A_ENABLE)) reg_rdata[N_PINS-1:0] = regs_q.enable;
        if (reg_addr == ADDR_W'(A_ROUTE))  reg_rdata             = regs_q.route;
        for (int i = 0; i < N_PINS; i++) begin
            if (reg_addr == ADDR_W'(A_CFG0 + CFG_STRIDE * i)) begin
                reg_rdata[0]   = pin_cur[i];
                reg_rdata[3:1] = regs_q.mode[3*i +: 3];
                reg_rdata[4]   = regs_q.prst[i];
            end
        end
    end

    wic_route #(.N_PINS(N_PINS), .N_PERIPH(N_PERIPH)) u_route (
        .status       (regs_q.status),
        .enable       (regs_q.enable),
        .route        (regs_q.route),
        .periph_irq   (periph_irq),
        .pin_irq_o    (pin_irq_o),
        .periph_irq_o (periph_irq_o),
        .wake_o       (wake_o)
    );
endmodule

// File: rtl/wic_checker.sv
module wic_checker
    import wic_pkg::*;
#(
    parameter int N_PINS   = 4,
    parameter int N_PERIPH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_PINS-1:0]   status,
    input logic [N_PINS-1:0]   hit,
    input logic [N_PINS-1:0]   prst,
    input logic [3*N_PINS-1:0] mode_flat,
    input logic                pin_irq_o,
    input logic                wake_o,
    input logic [N_PERIPH-1:0] periph_irq,
    input logic [N_PERIPH-1:0] periph_irq_o
);
    for (genvar g = 0; g < N_PINS; g++) begin : g_chk
        p_set_by_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[g]) |-> $past(hit[g]));
        p_none_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[3*g +: 3] == TRIG_NONE) |-> !hit[g]);
        p_hold_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            prst[g] |=> !status[g]);
    end

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_irq_o |-> (status != '0));
    p_periph_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_irq_o & ~periph_irq) == '0);
    p_wake_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ((periph_irq != '0) || (status != '0)));
endmodule

bind wake_irq_ctrl wic_checker #(.N_PINS(N_PINS), .N_PERIPH(N_PERIPH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .status       (status_vec),
    .hit          (pin_hit),
    .prst         (prst_vec),
    .mode_flat    (mode_flat),
    .pin_irq_o    (pin_irq_o),
    .wake_o       (wake_o),
    .periph_irq   (periph_irq),
    .periph_irq_o (periph_irq_o)
);

// File: tb/wake_irq_ctrl_tb.sv
module wake_irq_ctrl_tb;
    localparam int NPIN = 4;
    localparam int NPER = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NPIN-1:0] wake_pin = '0;
    logic [NPER-1:0] periph_irq = '0;
    logic            pin_irq_o;
    logic [NPER-1:0] periph_irq_o;
    logic            wake_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    wake_irq_ctrl #(.N_PINS(NPIN), .N_PERIPH(NPER), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_pin(wake_pin),
        .periph_irq(periph_irq), .pin_irq_o(pin_irq_o),
        .periph_irq_o(periph_irq_o), .wake_o(wake_o)
    );

    // Bench model, built from the requirements
    logic [NPIN-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_st = '0, m_en = '0, m_prst = '0;
    logic [31:0]     m_route = '0;
    logic [2:0]      m_mode [NPIN];
    logic [NPIN-1:0] cp = '0;
    logic [NPER-1:0] cper = '0;

    function automatic logic [31:0] rmask();
        logic [31:0] m;
        m = '0;
        m[0 +: NPER]  = '1;
        m[16 +: NPER] = '1;
        m[8 +: NPIN]  = '1;
        m[24 +: NPIN] = '1;
        return m;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 12'h310) r[NPIN-1:0] = m_st;
        if (a == 12'h314) r[NPIN-1:0] = m_en;
        if (a == 12'h31C) r = m_route;
        for (int i = 0; i < NPIN; i++)
            if ({20'd0, a} == 32'h330 + 8 * i) r = {27'd0, m_prst[i], m_mode[i], m_s2[i]};
        return r;
    endfunction

    task automatic model_update(input logic [NPIN-1:0] pins, input logic wr,
                                input logic [11:0] a, input logic [31:0] wd);
        logic [NPIN-1:0] hit, clr;
        hit = '0;
        for (int i = 0; i < NPIN; i++) begin
            case (m_mode[i])
                3'd0: hit[i] = !m_s2[i];
                3'd1: hit[i] = m_s2[i];
                3'd2: hit[i] = m_prev[i] && !m_s2[i];
                3'd3: hit[i] = !m_prev[i] && m_s2[i];
                3'd6: hit[i] = m_prev[i] ^ m_s2[i];
                default: hit[i] = 1'b0;
            endcase
        end
        hit = hit & ~m_prst;
        clr = (wr && a == 12'h318) ? wd[NPIN-1:0] : '0;
        m_st = ((m_st & ~clr) | hit) & ~m_prst;
        if (wr && a == 12'h314) m_en = wd[NPIN-1:0];
        if (wr && a == 12'h31C) m_route = wd & rmask();
        for (int i = 0; i < NPIN; i++)
            if (wr && ({20'd0, a} == 32'h330 + 8 * i)) begin
                m_mode[i] = wd[3:1];
                m_prst[i] = wd[4];
            end
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pins;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive, check outputs (and optionally a read), advance model
    task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                        input bit do_rd, input string tag);
        @(negedge clk);
        wake_pin = cp; periph_irq = cper; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        chk("R7 pin_irq_o", {31'd0, pin_irq_o}, {31'd0, |(m_st & m_en & m_route[8 +: NPIN])});
        chk("R8 periph_irq_o", {29'd0, periph_irq_o}, {29'd0, cper & m_route[0 +: NPER]});
        chk("R9 wake_o", {31'd0, wake_o},
            {31'd0, (|(cper & m_route[16 +: NPER])) | (|(m_st & m_route[24 +: NPIN]))});
        if (do_rd) chk(tag, reg_rdata, model_read(a));
        @(posedge clk);
        model_update(cp, wr, a, wd);
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] wd);
        step(1'b1, a, wd, 1'b0, "");
    endtask
    task automatic rd_reg(input logic [11:0] a, input string tag);
        step(1'b0, a, 32'd0, 1'b1, tag);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 12'h000, 32'd0, 1'b0, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPIN; i++) m_mode[i] = 3'd4;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd_reg(12'h310, "R1 status");
        rd_reg(12'h314, "R1 enable");
        rd_reg(12'h31C, "R1 route");
        rd_reg(12'h330, "R1 cfg0");
        chk("R1 cfg0 literal", model_read(12'h330), 32'h8);
        chk("R1 outputs", {29'd0, pin_irq_o, wake_o, periph_irq_o[0]}, 32'd0);

        // R2: synchronised pin value in cfg bit 0
        cp[1] = 1'b1;
        for (int i = 0; i < 4; i++) rd_reg(12'h338, "R2 cfg1 bit0");
        rd_reg(12'h318, "R2 clear reads zero");

        wr_reg(12'h314, 32'hF);
        wr_reg(12'h31C, 32'hFFFF_FFFF);
        rd_reg(12'h31C, "R11 route mask");

        // R4: rising, falling, either edge on pin 0
        wr_reg(12'h330, 32'd3 << 1);
        cp[0] = 1'b1; idle(4); rd_reg(12'h310, "R4 rising");
        wr_reg(12'h318, 32'h1); rd_reg(12'h310, "R4 cleared");
        wr_reg(12'h330, 32'd2 << 1);
        cp[0] = 1'b0; idle(4); rd_reg(12'h310, "R4 falling");
        wr_reg(12'h318, 32'h1);
        wr_reg(12'h330, 32'd6 << 1);
        cp[0] = 1'b1; idle(4); rd_reg(12'h310, "R4 either up");
        wr_reg(12'h318, 32'h1);
        cp[0] = 1'b0; idle(4); rd_reg(12'h310, "R4 either down");

        // R6: clear with zero has no effect, one clears
        wr_reg(12'h318, 32'h0); rd_reg(12'h310, "R6 zero clear");
        wr_reg(12'h314, 32'h0); rd_reg(12'h314, "R7 enable off");
        wr_reg(12'h314, 32'hFFFF_FFFF); rd_reg(12'h314, "R11 enable mask");
        wr_reg(12'h318, 32'h1); rd_reg(12'h310, "R6 one clears");

        // R3 and R6: level high held through a clear
        wr_reg(12'h340, 32'd1 << 1);
        cp[2] = 1'b1; idle(4);
        wr_reg(12'h318, 32'h4); rd_reg(12'h310, "R3 R6 trigger wins");
        cp[2] = 1'b0; idle(4);
        wr_reg(12'h318, 32'h4); rd_reg(12'h310, "R3 level gone");
        wr_reg(12'h340, 32'd0 << 1); idle(1); rd_reg(12'h310, "R3 level low");

        // R5: modes 4, 5, 7 never trigger
        wr_reg(12'h340, 32'd4 << 1); wr_reg(12'h318, 32'hF);
        cp[2] = 1'b1; idle(3); cp[2] = 1'b0; idle(3); rd_reg(12'h310, "R5 mode4");
        wr_reg(12'h340, 32'd5 << 1);
        cp[2] = 1'b1; idle(3); rd_reg(12'h310, "R5 mode5");
        wr_reg(12'h340, 32'd7 << 1);
        cp[2] = 1'b0; idle(3); rd_reg(12'h310, "R5 mode7");

        // R10: hold bit on pin 3 in level-low mode
        wr_reg(12'h348, 32'h10 | (32'd0 << 1)); idle(3); rd_reg(12'h310, "R10 held");
        rd_reg(12'h348, "R10 cfg3 readback");
        wr_reg(12'h348, 32'd0); idle(2); rd_reg(12'h310, "R10 released");

        // R11: unimplemented pin and unmapped offsets
        wr_reg(12'h350, 32'hFFFF_FFFF); rd_reg(12'h350, "R11 pin4 cfg");
        rd_reg(12'h334, "R11 gap offset");

        // R8, R9: peripheral routing
        cper = 3'b101; idle(2); wr_reg(12'h31C, 32'h0001_0002); cper = 3'b011; idle(2);

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            int op;
            logic [31:0] wd;
            if ($urandom % 4 == 0) cp[$urandom % NPIN] ^= 1'b1;
            if ($urandom % 8 == 0) cper = NPER'($urandom);
            op = $urandom % 10;
            wd = $urandom;
            case (op)
                0: wr_reg(12'h314, wd);
                1: wr_reg(12'h31C, wd);
                2: wr_reg(12'h318, wd);
                3: begin
                    wd[4] = ($urandom % 5 == 0);
                    wr_reg(12'h330 + 12'(8 * ($urandom % 5)), wd);
                end
                default: begin
                    logic [11:0] ra;
                    case ($urandom % 6)
                        0: ra = 12'h310;
                        1: ra = 12'h314;
                        2: ra = 12'h31C;
                        3: ra = 12'h318;
                        default: ra = 12'h330 + 12'(8 * ($urandom % 5));
                    endcase
                    rd_reg(ra, "R2 random read");
                end
            endcase
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule